// File: doc/BRIEF.md
# Eight-Bit Timer with Waveform Generator

This block is an eight-bit counter that advances on a one-cycle tick supplied by an external prescaler, paired with a compare unit and a single waveform output. One control byte picks one of four counting sequences: a free-running wrap, a clear-on-compare period, a single-slope PWM and a dual-slope (up/down) PWM. The same byte sets how the compare event drives the output pin and whether the counter runs. A compare register sets the match point. In the two PWM sequences, writes to it are staged and take effect only at a fixed point of the count. Two sticky event flags, overflow and compare match, are cleared by writing ones to them.

Software can also force a compare event by setting a strobe bit in the control byte. This applies the configured pin action at once and leaves the flags and the counter untouched. An enable output tells the surrounding port logic when the waveform pin should take over the pad.

Top module: `wave_timer`

## Requirements
- R1: After reset the count, both flags, the waveform output, the override enable, the control readback and the compare readback are all zero; control readback bit 7 (the force strobe) always reads zero.
- R2: Control bit 3 and bit 6 form the mode {bit3,bit6}: 00 free-running, 01 dual-slope PWM, 10 clear-on-compare, 11 single-slope PWM; in free-running and single-slope PWM the count goes up by one per step and wraps from 0xFF to 0x00.
- R3: In clear-on-compare mode a step taken while the count equals the active compare value returns the count to 0x00. Otherwise the count goes up by one and wraps at 0xFF.
- R4: In dual-slope PWM the count rises to 0xFF, then falls to 0x00, then rises again (…0xFE,0xFF,0xFE…0x01,0x00,0x01…). Leaving that mode resets the direction to upward.
- R5: Control bits 2:0 equal to 000 stop the counter. Otherwise the counter takes one step per clock cycle in which the tick input is high, and holds in all other cycles.
- R6: A compare write becomes active at once in the two non-PWM modes. In both PWM modes it is staged, and the staged value becomes active on the step that leaves count 0xFF. The compare readback returns the last written value.
- R7: The overflow flag (flag bit 0) is set by a step taken at count 0xFF in free-running, clear-on-compare and single-slope modes, and by a step taken at count 0x00 in dual-slope mode.
- R8: The match flag (flag bit 1) is set by a step taken while the count equals the active compare value. Writing a one to a flag bit clears that flag. A set event in the same cycle as a clear wins.
- R9: In non-PWM modes, a match changes the output according to control bits 5:4: 00 no change, 01 toggle, 10 drive low, 11 drive high.
- R10: In single-slope PWM, output mode 10 drives the pin low on a match and high on the step into 0x00. Mode 11 does the opposite. If both happen on the same step, the 0x00 action wins. Mode 01 leaves the pin unchanged.
- R11: In dual-slope PWM, output mode 10 drives the pin low on a match while counting up and high on a match while counting down. Mode 11 does the opposite, and mode 01 leaves the pin unchanged. A match at 0xFF counts as upward.
- R12: A control write with bit 7 set and a non-PWM mode in the written byte applies the written output mode action to the pin in the next cycle. It sets no flag and does not alter the count. In PWM modes the strobe is ignored.
- R13: The override enable is high whenever either output mode bit (control bits 5:4) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle prescaled count enable |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_q | output | 8 | Control byte readback (bit 7 always 0) |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare register write data |
| cmp_q | output | 8 | Last written compare value |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Clear mask: bit 0 overflow, bit 1 match |
| count_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 1 | Sticky compare match flag |
| wave_out | output | 1 | Waveform output |
| wave_en | output | 1 | Override enable for the pad |

## Verification
The hardest situations to reach are those where two events land on the same step. Examples are a staged compare write that arrives just before the count leaves 0xFF in a PWM mode, a compare value of 0xFF in single-slope PWM where the match and the return to zero coincide, and a clear-on-compare value written below the current count so that the counter has to wrap the long way. The stimulus places compare writes at chosen counts while the counter runs, uses both a full-rate tick and a sparse one, and clears flags on a fixed cadence so that a clear sometimes collides with a set. A behavioural model in the bench tracks count, direction, active compare value, pin and flags and is compared with the outputs on every cycle.

// File: rtl/wtimer_pkg.sv
package wtimer_pkg;

    typedef enum logic [1:0] {
        WM_FREE  = 2'b00,
        WM_DUAL  = 2'b01,
        WM_CLEAR = 2'b10,
        WM_FAST  = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_LOW    = 2'b10,
        OM_HIGH   = 2'b11
    } omode_e;

    typedef struct packed {
        logic       strobe;
        logic       mode_lo;
        logic [1:0] om;
        logic       mode_hi;
        logic [2:0] csel;
    } ctl_t;

    function automatic wmode_e mode_of(ctl_t c);
        return wmode_e'({c.mode_hi, c.mode_lo});
    endfunction

    function automatic logic is_pwm(wmode_e m);
        return (m == WM_DUAL) || (m == WM_FAST);
    endfunction

endpackage

// File: rtl/wt_counter.sv
module wt_counter
    import wtimer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  wmode_e       mode,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt,
    output logic         down
);
    localparam logic [W-1:0] MAX  = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= ZERO;
            down <= 1'b0;
        end else begin
            if (mode != WM_DUAL) down <= 1'b0;
            if (step) begin
                case (mode)
                    WM_DUAL: begin
                        if (!down) begin
                            if (cnt == MAX) begin
                                down <= 1'b1;
                                cnt  <= MAX - ONE;
                            end else begin
                                cnt <= cnt + ONE;
                            end
                        end else if (cnt == ZERO) begin
                            down <= 1'b0;
                            cnt  <= ONE;
                        end else begin
                            cnt <= cnt - ONE;
                        end
                    end
                    WM_CLEAR: cnt <= (cnt == top_val) ? ZERO : cnt + ONE;
                    default:  cnt <= cnt + ONE;
                endcase
            end
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !step |=> cnt == $past(cnt));

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (step && mode == WM_CLEAR && cnt == top_val) |=> cnt == ZERO);

    assert_turn_R4: assert property (@(posedge clk) disable iff (rst)
        (step && mode == WM_DUAL && !down && cnt == MAX) |=> (down && cnt == MAX - ONE));

endmodule

// File: rtl/wt_compare.sv
module wt_compare
    import wtimer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  wmode_e       mode,
    input  logic         step,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] staged,
    output logic [W-1:0] active,
    output logic         match
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic pwm;
    logic load_pt;

    assign pwm     = is_pwm(mode);
    assign load_pt = step && (cnt == MAX);
    assign match   = step && (cnt == active);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
            active <= '0;
        end else begin
            if (wr) staged <= wdata;
            if (!pwm && wr)        active <= wdata;
            else if (pwm && load_pt) active <= staged;
        end
    end

    assert_staged_R6: assert property (@(posedge clk) disable iff (rst)
        (pwm && !load_pt) |=> active == $past(active));

    assert_direct_R6: assert property (@(posedge clk) disable iff (rst)
        (!pwm && wr) |=> active == $past(wdata));

endmodule

// File: rtl/wt_wavegen.sv
module wt_wavegen
    import wtimer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  wmode_e       mode,
    input  omode_e       om,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  logic         down,
    input  logic         match,
    input  logic         force_req,
    input  omode_e       force_om,
    output logic         wave
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic bottom;
    assign bottom = step && (cnt == MAX);

    function automatic logic apply_om(omode_e o, logic cur);
        case (o)
            OM_TOGGLE: return ~cur;
            OM_LOW:    return 1'b0;
            OM_HIGH:   return 1'b1;
            default:   return cur;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
        end else if (force_req) begin
            wave <= apply_om(force_om, wave);
        end else begin
            case (mode)
                WM_FAST: begin
                    if (om == OM_LOW) begin
                        if (bottom)     wave <= 1'b1;
                        else if (match) wave <= 1'b0;
                    end else if (om == OM_HIGH) begin
                        if (bottom)     wave <= 1'b0;
                        else if (match) wave <= 1'b1;
                    end
                end
                WM_DUAL: begin
                    if (match && om == OM_LOW)  wave <= down;
                    if (match && om == OM_HIGH) wave <= ~down;
                end
                default: begin
                    if (match) wave <= apply_om(om, wave);
                end
            endcase
        end
    end

    assert_force_hi_R12: assert property (@(posedge clk) disable iff (rst)
        (force_req && force_om == OM_HIGH) |=> wave);

    assert_force_lo_R12: assert property (@(posedge clk) disable iff (rst)
        (force_req && force_om == OM_LOW) |=> !wave);

    assert_fast_bottom_R10: assert property (@(posedge clk) disable iff (rst)
        (!force_req && mode == WM_FAST && om == OM_LOW && bottom) |=> wave);

endmodule

// File: rtl/wave_timer.sv
module wave_timer
    import wtimer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ctl_we,
    input  logic [7:0]   ctl_wdata,
    output logic [7:0]   ctl_q,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_q,
    input  logic         flag_clr_we,
    input  logic [1:0]   flag_clr,
    output logic [W-1:0] count_q,
    output logic         ovf_flag,
    output logic         match_flag,
    output logic         wave_out,
    output logic         wave_en
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    ctl_t   ctl;
    ctl_t   wr_ctl;
    wmode_e mode;
    omode_e om;
    logic   step;
    logic   down;
    logic   match;
    logic   ovf_ev;
    logic   force_req;
    logic [W-1:0] active;

    assign wr_ctl    = ctl_t'(ctl_wdata);
    assign mode      = mode_of(ctl);
    assign om        = omode_e'(ctl.om);
    assign step      = tick && (ctl.csel != 3'b000);
    assign force_req = ctl_we && wr_ctl.strobe && !is_pwm(mode_of(wr_ctl));
    assign ovf_ev    = step && ((mode == WM_DUAL) ? (count_q == '0) : (count_q == MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (ctl_we) begin
            ctl        <= wr_ctl;
            ctl.strobe <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag   <= 1'b0;
            match_flag <= 1'b0;
        end else begin
            if (ovf_ev)                         ovf_flag <= 1'b1;
            else if (flag_clr_we && flag_clr[0]) ovf_flag <= 1'b0;
            if (match)                          match_flag <= 1'b1;
            else if (flag_clr_we && flag_clr[1]) match_flag <= 1'b0;
        end
    end

    assign ctl_q   = ctl;
    assign wave_en = |ctl.om;

    wt_counter #(.W(W)) u_counter (
        .clk(clk), .rst(rst), .step(step), .mode(mode),
        .top_val(active), .cnt(count_q), .down(down)
    );

    wt_compare #(.W(W)) u_compare (
        .clk(clk), .rst(rst), .wr(cmp_we), .wdata(cmp_wdata), .mode(mode),
        .step(step), .cnt(count_q), .staged(cmp_q), .active(active), .match(match)
    );

    wt_wavegen #(.W(W)) u_wavegen (
        .clk(clk), .rst(rst), .mode(mode), .om(om), .step(step), .cnt(count_q),
        .down(down), .match(match), .force_req(force_req),
        .force_om(omode_e'(wr_ctl.om)), .wave(wave_out)
    );

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> ovf_flag);

    assert_match_set_R8: assert property (@(posedge clk) disable iff (rst)
        match |=> match_flag);

    assert_force_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (force_req && !match && !match_flag) |=> !match_flag);

    assert_strobe_zero_R1: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> !ctl_q[7]);

endmodule

// File: tb/wave_timer_tb.sv
module wave_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_q;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = 8'h00;
    logic [7:0] cmp_q;
    logic       flag_clr_we = 1'b0;
    logic [1:0] flag_clr = 2'b00;
    logic [7:0] count_q;
    logic       ovf_flag, match_flag, wave_out, wave_en;

    always #4 clk = ~clk;

    wave_timer u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_q(cmp_q),
        .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
        .count_q(count_q), .ovf_flag(ovf_flag), .match_flag(match_flag),
        .wave_out(wave_out), .wave_en(wave_en)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int tick_period = 1;
    int clr_period  = 0;
    string cnt_req  = "R1";
    string wave_req = "R1";

    // behavioural reference state
    int m_cnt, m_dir, m_act, m_buf, m_wave, m_ovf, m_mat, m_ctl;

    always @(posedge clk) begin
        int mode, om, stp, mat, ovf, wv, nc, nd, na, nb, fo, fm;
        if (rst) begin
            m_cnt = 0; m_dir = 0; m_act = 0; m_buf = 0;
            m_wave = 0; m_ovf = 0; m_mat = 0; m_ctl = 0;
        end else begin
            mode = ((m_ctl >> 3) & 1) * 2 + ((m_ctl >> 6) & 1);
            om   = (m_ctl >> 4) & 3;
            stp  = (tick && (m_ctl & 7) != 0) ? 1 : 0;
            mat  = (stp && m_cnt == m_act) ? 1 : 0;
            ovf  = (stp && ((mode == 1) ? (m_cnt == 0) : (m_cnt == 255))) ? 1 : 0;
            wv = m_wave;
            if (mode == 3) begin
                if (stp && m_cnt == 255 && om >= 2) wv = (om == 2) ? 1 : 0;
                else if (mat && om >= 2)            wv = (om == 2) ? 0 : 1;
            end else if (mode == 1) begin
                if (mat && om >= 2) wv = (om == 2) ? m_dir : 1 - m_dir;
            end else if (mat) begin
                if (om == 1) wv = 1 - wv;
                else if (om == 2) wv = 0;
                else if (om == 3) wv = 1;
            end
            fm = ((ctl_wdata >> 3) & 1) * 2 + ((ctl_wdata >> 6) & 1);
            fo = (ctl_wdata >> 4) & 3;
            if (ctl_we && ctl_wdata[7] && (fm == 0 || fm == 2)) begin
                wv = m_wave;
                if (fo == 1) wv = 1 - wv;
                else if (fo == 2) wv = 0;
                else if (fo == 3) wv = 1;
            end
            nc = m_cnt; nd = (mode == 1) ? m_dir : 0;
            if (stp) begin
                if (mode == 1) begin
                    if (m_dir == 0) begin
                        if (m_cnt == 255) begin nd = 1; nc = 254; end else nc = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin nd = 0; nc = 1; end else nc = m_cnt - 1;
                    end
                end else if (mode == 2 && m_cnt == m_act) nc = 0;
                else nc = (m_cnt + 1) % 256;
            end
            nb = cmp_we ? int'(cmp_wdata) : m_buf;
            na = m_act;
            if ((mode == 0 || mode == 2) && cmp_we) na = cmp_wdata;
            else if ((mode == 1 || mode == 3) && stp && m_cnt == 255) na = m_buf;
            if (ovf) m_ovf = 1; else if (flag_clr_we && flag_clr[0]) m_ovf = 0;
            if (mat) m_mat = 1; else if (flag_clr_we && flag_clr[1]) m_mat = 0;
            if (ctl_we) m_ctl = ctl_wdata & 8'h7F;
            m_cnt = nc; m_dir = nd; m_act = na; m_buf = nb; m_wave = wv;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cycles, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge; drive next inputs
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(cnt_req, "count", count_q, m_cnt);
            chk("R7", "overflow flag", ovf_flag, m_ovf);
            chk("R8", "match flag", match_flag, m_mat);
            chk(wave_req, "wave", wave_out, m_wave);
            chk("R13", "override", wave_en, ((m_ctl >> 4) & 3) != 0);
            chk("R1", "control readback", ctl_q, m_ctl);
            chk("R6", "compare readback", cmp_q, m_buf);
        end
        tick <= (tick_period > 0) && (cycles % tick_period == 0);
        if (clr_period > 0 && cycles % clr_period == 0) begin
            flag_clr_we <= 1'b1; flag_clr <= 2'b11;
        end else begin
            flag_clr_we <= 1'b0; flag_clr <= 2'b00;
        end
        if (cycles > 200000) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put_ctl(logic [7:0] v);
        @(negedge clk); ctl_we <= 1'b1; ctl_wdata <= v;
        @(negedge clk); ctl_we <= 1'b0; ctl_wdata <= 8'h00;
    endtask

    task automatic put_cmp(logic [7:0] v);
        @(negedge clk); cmp_we <= 1'b1; cmp_wdata <= v;
        @(negedge clk); cmp_we <= 1'b0;
    endtask

    task automatic wait_count(int v);
        for (int i = 0; i < 3000 && count_q != v[7:0]; i++) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        // R1: reset state, checked at the ports
        chk("R1", "count after reset", count_q, 0);
        chk("R1", "flags after reset", {ovf_flag, match_flag}, 0);
        chk("R1", "wave after reset", {wave_out, wave_en}, 0);
        chk("R1", "readbacks after reset", {ctl_q, cmp_q}, 0);
        rst <= 1'b0;
        wait_cyc(2);

        // R2 free-running, R9 toggle on match
        cnt_req = "R2"; wave_req = "R9";
        put_cmp(8'h40);
        put_ctl(8'h11);
        clr_period = 97;
        wait_cyc(600);
        put_ctl(8'h31);
        wait_cyc(300);

        // R3 clear-on-compare, sparse tick, R5 gating by tick
        cnt_req = "R3"; tick_period = 3;
        put_cmp(8'd20);
        put_ctl(8'h29);
        wait_cyc(200);
        wait_count(15);
        put_cmp(8'd5);           // below the count: long wrap
        wait_cyc(900);

        // R12 force strobe in non-PWM mode
        wave_req = "R12"; tick_period = 0;
        wait_cyc(3);
        put_ctl(8'hB9);          // force high
        wait_cyc(3);
        put_ctl(8'hA9);          // force low
        wait_cyc(3);
        put_ctl(8'h99);          // force toggle
        wait_cyc(3);
        put_ctl(8'h89);          // force with pin disconnected
        wait_cyc(3);

        // R5 stopped counter ignores ticks
        cnt_req = "R5"; tick_period = 1;
        put_ctl(8'h28);
        wait_cyc(50);

        // R10 single-slope PWM with staged compare, R12 strobe ignored
        cnt_req = "R2"; wave_req = "R10";
        put_ctl(8'h69);
        put_cmp(8'h80);
        wait_count(8'h40);
        put_cmp(8'h30);
        wait_cyc(700);
        put_ctl(8'hE9);
        wait_cyc(20);
        put_ctl(8'h79);
        put_cmp(8'hFF);
        wait_cyc(600);
        put_cmp(8'h00);
        wait_cyc(600);

        // R11 dual-slope PWM, R4 direction, R6 staging at the top
        cnt_req = "R4"; wave_req = "R11";
        put_ctl(8'h61);
        put_cmp(8'h60);
        wait_cyc(1100);
        wait_count(8'hFC);
        put_cmp(8'hA0);
        wait_cyc(1100);
        put_ctl(8'h71);
        wait_cyc(1100);
        put_ctl(8'h51);          // output mode 01 in PWM: pin unchanged
        wait_cyc(600);
        tick_period = 2;
        put_ctl(8'h11);          // back to free-running, direction resets
        cnt_req = "R2";
        wait_cyc(600);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule